// File: doc/BRIEF.md
# Wait-State Memory-Mapped Register Slave

This block is a single-clock memory-mapped slave that holds a small array of data words and lets a master read and write them. It exists to give a bus fabric a slave whose access latency is controlled by parameters. It holds every transfer for a set number of cycles before completing it. Write data is merged byte by byte under a byte-enable mask.

One parameter selects how the stall is shown to the master. In handshake mode the slave drives a registered waitrequest. That signal is high whenever the slave is idle, and it drops only for the single cycle in which a presented transfer completes. In fixed mode, waitrequest is held low and the master counts the configured read and write wait cycles itself. Both modes run the same internal wait sequencer, so a transfer completes in the same cycle in either mode. The storage is built from one narrow array per byte lane with a registered read port, so that block RAM can be inferred.

Top module: `wss_slave`

## Requirements
- R1: In handshake mode, waitrequest comes from a register. It is high during reset and stays high in every cycle in which no transfer is completing, including idle cycles. It never depends combinationally on read or write.
- R2: In handshake mode, a transfer presented in cycle 0 sees waitrequest high in cycles 0 to N-1 and completes in cycle N. N is RD_WAIT for a read and WR_WAIT for a write, and a count below 1 is raised to 1. The master holds address, byteenable, read, write and writedata stable while waitrequest is high.
- R3: A read completes in a cycle in which readdata holds the addressed word, readdatavalid is high and waitrequest is low. read and write are never high together.
- R4: A write takes writedata into the addressed word on the clock edge that ends its completion cycle. A later read of that address returns the new data.
- R5: On a write, byteenable bit i controls writedata bits [8i+7:8i]. Bytes whose enable bit is 0 keep their old value, and an all-zero mask changes nothing.
- R6: readdatavalid is high for exactly one cycle for each completed read. In every other cycle readdata keeps its last value. readdata is 0 after reset.
- R7: In fixed mode, waitrequest is always 0. A read presented in cycle 0 raises readdatavalid with the data in cycle RD_WAIT, which is the same cycle as in handshake mode. The read count is at least 1.
- R8: In fixed mode with WR_WAIT set to 0, a write completes in the cycle in which it is presented, and a read issued in the very next cycle returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| address | input | ADDR_W | Word address |
| byteenable | input | DATA_W/8 | Byte lane mask for writes |
| read | input | 1 | Read request |
| write | input | 1 | Write request |
| writedata | input | DATA_W | Write data |
| readdata | output | DATA_W | Read data, registered |
| readdatavalid | output | 1 | High in the completion cycle of a read |
| waitrequest | output | 1 | Stall signal; high while idle in handshake mode, constant 0 in fixed mode |

## Verification
The bench counts the waitrequest-high cycles of every handshake transfer. A sequencer that is off by one, or that lets waitrequest fall while idle, shows up as a wrong count or a low idle sample. Partial and all-zero byte masks are read back word by word against a bench model, which catches lanes that are swapped or always written. The fixed-mode instance is checked with a zero-wait write followed by an immediate read. A slave that stalls that write, or that takes its data one cycle late, returns the old word. Checking readdatavalid in the cycle after each read catches a pulse that is too long and catches readdata that drifts.

// File: rtl/wss_pkg.sv
package wss_pkg;
  typedef enum logic {
    STALL_HANDSHAKE = 1'b0,
    STALL_FIXED     = 1'b1
  } stall_mode_e;
endpackage

// File: rtl/wss_wait_seq.sv
module wss_wait_seq #(
  parameter wss_pkg::stall_mode_e MODE = wss_pkg::STALL_HANDSHAKE,
  parameter int RD_WAIT = 2,
  parameter int WR_WAIT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_req,
  input  logic wr_req,
  output logic mem_we,
  output logic mem_re,
  output logic rdv,
  output logic wait_out
);
  localparam int RD_EFF  = (RD_WAIT < 1) ? 1 : RD_WAIT;
  localparam bit ZERO_WR = (MODE == wss_pkg::STALL_FIXED) && (WR_WAIT == 0);
  localparam int WR_EFF  = (WR_WAIT < 1) ? 1 : WR_WAIT;
  localparam int MAXW    = (RD_EFF > WR_EFF) ? RD_EFF : WR_EFF;
  localparam int CNT_W   = $clog2(MAXW + 2);

  logic             busy_q;
  logic             ready_q;
  logic             rdv_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nwait;
  logic [CNT_W-1:0] cnt_nxt;
  logic             req;
  logic             zero_fire;
  logic             arm_now;

  assign req       = rd_req | wr_req;
  assign nwait     = rd_req ? CNT_W'(RD_EFF) : CNT_W'(WR_EFF);
  assign cnt_nxt   = cnt_q + 1'b1;
  assign zero_fire = ZERO_WR && wr_req && !rd_req && !busy_q;
  assign arm_now   = (!busy_q && req && !zero_fire && (nwait == CNT_W'(1))) ||
                     (busy_q && !ready_q && (cnt_nxt == nwait));

  assign mem_re = rd_req && arm_now;
  assign mem_we = wr_req && !rd_req && (zero_fire || (busy_q && ready_q));
  assign rdv    = rdv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      rdv_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (!busy_q) begin
      if (req && !zero_fire) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(1);
        if (arm_now) begin
          ready_q <= 1'b1;
          rdv_q   <= rd_req;
        end
      end
    end else if (ready_q) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      rdv_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      if (arm_now) begin
        ready_q <= 1'b1;
        rdv_q   <= rd_req;
      end
    end
  end

  generate
    if (MODE == wss_pkg::STALL_HANDSHAKE) begin : g_hs
      logic wait_q;
      always_ff @(posedge clk) begin
        if (rst) wait_q <= 1'b1;
        else     wait_q <= !arm_now;
      end
      assign wait_out = wait_q;

      AST_WAIT_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> wait_out);  // R1
      AST_WAIT_FALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $fell(wait_out) |-> $past(req));  // R1
      AST_HOLD_DURING_WAIT: assert property (@(posedge clk) disable iff (rst)
        (req && wait_out) |=> (req && $stable(rd_req) && $stable(wr_req)));  // R2
    end else begin : g_fx
      assign wait_out = 1'b0;
    end
  endgenerate

  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req));  // R3
  AST_RDV_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
    rdv_q |-> !wait_out);  // R3
  AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rdv_q |=> !rdv_q);  // R6
endmodule

// File: rtl/wss_lane_array.sv
module wss_lane_array #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int BE_W  = DATA_W / 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] rdata_q;

  generate
    for (genvar l = 0; l < BE_W; l++) begin : g_lane
      logic [7:0] lane_mem [DEPTH];
      logic [7:0] lane_rd_q;
      always_ff @(posedge clk) begin
        if (we && be[l]) lane_mem[addr] <= wdata[8*l +: 8];
      end
      always_ff @(posedge clk) begin
        if (rst)     lane_rd_q <= 8'h00;
        else if (re) lane_rd_q <= lane_mem[addr];
      end
      assign rdata_q[8*l +: 8] = lane_rd_q;
    end
  endgenerate

  assign rdata = rdata_q;

  AST_RDATA_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    !$stable(rdata_q) |-> $past(re));  // R6
endmodule

// File: rtl/wss_slave.sv
module wss_slave #(
  parameter wss_pkg::stall_mode_e MODE = wss_pkg::STALL_HANDSHAKE,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int RD_WAIT = 2,
  parameter int WR_WAIT = 1,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] address,
  input  logic [BE_W-1:0]   byteenable,
  input  logic              read,
  input  logic              write,
  input  logic [DATA_W-1:0] writedata,
  output logic [DATA_W-1:0] readdata,
  output logic              readdatavalid,
  output logic              waitrequest
);
  logic mem_we;
  logic mem_re;

  wss_wait_seq #(
    .MODE    (MODE),
    .RD_WAIT (RD_WAIT),
    .WR_WAIT (WR_WAIT)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (read),
    .wr_req   (write),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .rdv      (readdatavalid),
    .wait_out (waitrequest)
  );

  wss_lane_array #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_arr (
    .clk   (clk),
    .rst   (rst),
    .we    (mem_we),
    .re    (mem_re),
    .addr  (address),
    .be    (byteenable),
    .wdata (writedata),
    .rdata (readdata)
  );

  AST_WRITE_NOT_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !waitrequest);  // R4
endmodule

// File: tb/tb_wss_slave.sv
`timescale 1ns/1ps
module tb_wss_slave;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int BW = DW / 8;
  localparam int DEPTH = 1 << AW;
  localparam int HS_RD = 3;
  localparam int HS_WR = 2;
  localparam int FX_RD = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [AW-1:0] h_addr = '0, f_addr = '0;
  logic [BW-1:0] h_be = '0, f_be = '0;
  logic          h_rd = 1'b0, h_wr = 1'b0, f_rd = 1'b0, f_wr = 1'b0;
  logic [DW-1:0] h_wd = '0, f_wd = '0;
  logic [DW-1:0] h_q, f_q;
  logic          h_v, f_v, h_w, f_w;

  wss_slave #(.MODE(wss_pkg::STALL_HANDSHAKE), .DATA_W(DW), .ADDR_W(AW),
              .RD_WAIT(HS_RD), .WR_WAIT(HS_WR)) dut (
    .clk(clk), .rst(rst), .address(h_addr), .byteenable(h_be), .read(h_rd),
    .write(h_wr), .writedata(h_wd), .readdata(h_q), .readdatavalid(h_v),
    .waitrequest(h_w));

  wss_slave #(.MODE(wss_pkg::STALL_FIXED), .DATA_W(DW), .ADDR_W(AW),
              .RD_WAIT(FX_RD), .WR_WAIT(0)) dut_fx (
    .clk(clk), .rst(rst), .address(f_addr), .byteenable(f_be), .read(f_rd),
    .write(f_wr), .writedata(f_wd), .readdata(f_q), .readdatavalid(f_v),
    .waitrequest(f_w));

  logic [DW-1:0] m_hs [DEPTH];
  logic [DW-1:0] m_fx [DEPTH];
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                          logic [BW-1:0] be);
    logic [DW-1:0] r = old;
    for (int i = 0; i < BW; i++) if (be[i]) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic hs_xfer(bit is_rd, logic [AW-1:0] a, logic [BW-1:0] be, logic [DW-1:0] d);
    int waits = 0;
    logic [DW-1:0] held;
    @(posedge clk); #1;
    h_addr = a; h_be = be; h_wd = d; h_rd = is_rd; h_wr = !is_rd;
    forever begin
      @(negedge clk);
      if (!h_w || waits > 40) break;
      waits++;
    end
    check(is_rd ? "R2 read wait count" : "R2 write wait count", DW'(waits),
          DW'(is_rd ? HS_RD : HS_WR));
    if (is_rd) begin
      check("R3 readdatavalid at completion", DW'(h_v), 1);
      check("R3 readdata at completion", h_q, m_hs[a]);
    end else begin
      m_hs[a] = merge(m_hs[a], d, be);
    end
    held = h_q;
    @(posedge clk); #1;
    h_rd = 0; h_wr = 0;
    @(negedge clk);
    check("R1 waitrequest high after completion", DW'(h_w), 1);
    if (is_rd) begin
      check("R6 readdatavalid one cycle", DW'(h_v), 0);
      check("R6 readdata held", h_q, held);
    end
  endtask

  task automatic fx_xfer(bit is_rd, logic [AW-1:0] a, logic [BW-1:0] be, logic [DW-1:0] d);
    @(posedge clk); #1;
    f_addr = a; f_be = be; f_wd = d; f_rd = is_rd; f_wr = !is_rd;
    if (is_rd) begin
      for (int k = 0; k <= FX_RD; k++) begin
        @(negedge clk);
        check("R7 waitrequest zero", DW'(f_w), 0);
        check("R7 readdatavalid timing", DW'(f_v), DW'(k == FX_RD));
        if (k == FX_RD) check("R7 readdata", f_q, m_fx[a]);
        if (k < FX_RD) @(posedge clk);
      end
    end else begin
      @(negedge clk);
      check("R8 no valid during write", DW'(f_v), 0);
      m_fx[a] = merge(m_fx[a], d, be);
    end
    @(posedge clk); #1;
    f_rd = 0; f_wr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 waitrequest high in reset", DW'(h_w), 1);
    check("R6 readdata zero in reset", h_q, 0);
    #1; rst = 0;
    @(negedge clk); @(negedge clk);
    check("R1 waitrequest high while idle", DW'(h_w), 1);
    check("R6 readdatavalid low while idle", DW'(h_v), 0);
    check("R7 fixed waitrequest zero", DW'(f_w), 0);

    for (int i = 0; i < DEPTH; i++) begin
      m_hs[i] = '0; m_fx[i] = '0;
      hs_xfer(0, AW'(i), '1, 32'hA500_0000 + DW'(i));
      fx_xfer(0, AW'(i), '1, 32'h5A00_0000 + DW'(i));
    end
    // R4 full writes read back
    hs_xfer(1, 4'd3, '0, '0);
    fx_xfer(1, 4'd3, '0, '0);
    // R5 partial and empty masks
    hs_xfer(0, 4'd5, 4'b0101, 32'h1122_3344);
    hs_xfer(1, 4'd5, '0, '0);
    hs_xfer(0, 4'd6, 4'b0000, 32'hFFFF_FFFF);
    hs_xfer(1, 4'd6, '0, '0);
    fx_xfer(0, 4'd7, 4'b1000, 32'hDEAD_BEEF);
    fx_xfer(1, 4'd7, '0, '0);
    // R8 zero-wait write then read on the very next cycle
    @(posedge clk); #1;
    f_addr = 4'd9; f_be = '1; f_wd = 32'hCAFE_F00D; f_wr = 1; f_rd = 0;
    m_fx[9] = 32'hCAFE_F00D;
    @(posedge clk); #1;
    f_wr = 0; f_rd = 1;
    for (int k = 0; k <= FX_RD; k++) begin
      @(negedge clk);
      if (k == FX_RD) begin
        check("R8 back-to-back valid", DW'(f_v), 1);
        check("R8 back-to-back data", f_q, 32'hCAFE_F00D);
      end
      if (k < FX_RD) @(posedge clk);
    end
    @(posedge clk); #1; f_rd = 0;

    for (int n = 0; n < 120; n++) begin
      logic [AW-1:0] a = AW'($urandom % DEPTH);
      logic [BW-1:0] be = BW'($urandom);
      logic [DW-1:0] d = $urandom;
      bit r = $urandom % 2;
      hs_xfer(r, a, be, d);
      fx_xfer(r, a, be, d);
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule